// File: doc/BRIEF.md
# Masked Dual Alarm Comparator

This block watches a running calendar and raises alarms when it reaches preset times. Two alarm channels each hold a target time made of six fields: second, minute, hour, day-of-week, day-of-month and month. Each field has its own match enable. A channel compares the target against the current time only when the timekeeper pulses its update strobe. If every enabled field agrees, the channel sets a sticky status flag. Software polls that flag and clears it with a pulse.

A channel fires only while it is armed, and it becomes armed through a write pulse. In single-shot mode the channel disarms itself when it fires, so software must re-arm it before it can fire again. In repeat mode the channel stays armed and fires on every matching update. Examples are once per minute when only the second field is enabled, or once per hour when only the minute field is enabled. An active-low interrupt line is driven low while any flag whose interrupt enable is set is high.

The alarm registers, enables and mode bits enter as plain input ports. The time counters and register storage sit outside this block.

Top module: `alarm_pair_cmp`

## Requirements
- R1: After reset both flags read 0, `irq_n` reads 1 and both channels are disarmed, so a matching update strobe sets no flag until the channel has been armed.
- R2: When an armed channel sees `tick` high and all of its enabled fields equal the current time, its flag is 1 after the next rising clock edge.
- R3: A field whose enable bit is 0 is treated as matching, whatever its value. The enable bits per channel are ordered bit 0 second, bit 1 minute, bit 2 hour, bit 3 day-of-week, bit 4 day, bit 5 month, and channel i uses `alm_en[6*i +: 6]`.
- R4: A channel whose six enable bits are all 0 never sets its flag, even while armed and strobed.
- R5: Comparison happens only in cycles with `tick` high. A match held over cycles without the strobe sets nothing.
- R6: A set flag stays 1 until a `flag_clr` pulse for that channel, after which it reads 0 from the next edge.
- R7: When a channel fires in the same cycle as its clear pulse, the flag ends up 1.
- R8: In single-shot mode (`alm_rpt[i]`=0) a channel disarms itself when it fires. Later matches set nothing until an `alm_arm[i]` pulse is given, and that pulse takes effect at the following edge.
- R9: In repeat mode (`alm_rpt[i]`=1) a channel stays armed after firing and sets its flag on every later matching strobe without re-arming.
- R10: `irq_n` is 0 exactly while some channel has both its flag and its `irq_en` bit at 1. It follows the flags with no extra delay.
- R11: The two channels are independent. Each has its own target, enables, mode, arm, clear and flag.
- R12: A mismatch in any enabled field, including day-of-week, prevents firing. The target per channel is packed as {month[3:0], day[4:0], dow[2:0], hour[4:0], minute[5:0], second[5:0]} with the second field at the LSB, and channel i uses `alm_time[29*i +: 29]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle strobe marking a new time value |
| cur_sec | input | 6 | Current second |
| cur_min | input | 6 | Current minute |
| cur_hour | input | 5 | Current hour |
| cur_dow | input | 3 | Current day of week |
| cur_day | input | 5 | Current day of month |
| cur_mon | input | 4 | Current month |
| alm_time | input | 58 | Packed target times, 29 bits per channel |
| alm_en | input | 12 | Field match enables, 6 per channel |
| alm_rpt | input | 2 | Repeat mode per channel |
| alm_arm | input | 2 | Arm pulse per channel |
| flag_clr | input | 2 | Flag clear pulse per channel |
| irq_en | input | 2 | Interrupt enable per channel |
| alm_flag | output | 2 | Sticky alarm status flags |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A flag changes at the first rising edge after the cycle that carries the strobe or the clear. The interrupt line changes in that same cycle, because it decodes the registered flags directly. An arm pulse also lands at an edge, so the bench always gives the arm in one step and the matching strobe in a later step. The driver applies each step at a falling edge and queues the flag pair and interrupt level expected after the next rising edge. The monitor pops that item 2 ns after the rising edge and compares it, which gives exactly one cycle of latency for every result.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int NFIELD = 6;

  typedef struct packed {
    logic armed;
    logic flag;
  } alm_state_t;
endpackage

// File: rtl/alm_rst_sync.sv
module alm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/alm_match.sv
module alm_match
  import alm_pkg::*;
#(
  parameter  int SEC_W  = 6,
  parameter  int MIN_W  = 6,
  parameter  int HOUR_W = 5,
  parameter  int DOW_W  = 3,
  parameter  int DAY_W  = 5,
  parameter  int MON_W  = 4,
  localparam int TW     = SEC_W + MIN_W + HOUR_W + DOW_W + DAY_W + MON_W
) (
  input  logic [TW-1:0]     cur_t,
  input  logic [TW-1:0]     tgt_t,
  input  logic [NFIELD-1:0] fld_en,
  output logic              all_ok
);
  localparam int LO_MIN  = SEC_W;
  localparam int LO_HOUR = LO_MIN + MIN_W;
  localparam int LO_DOW  = LO_HOUR + HOUR_W;
  localparam int LO_DAY  = LO_DOW + DOW_W;
  localparam int LO_MON  = LO_DAY + DAY_W;
  localparam int FLD_LO [NFIELD] = '{0, LO_MIN, LO_HOUR, LO_DOW, LO_DAY, LO_MON};
  localparam int FLD_W  [NFIELD] = '{SEC_W, MIN_W, HOUR_W, DOW_W, DAY_W, MON_W};

  logic [NFIELD-1:0] fld_ok;

  for (genvar f = 0; f < NFIELD; f++) begin : g_fld
    localparam int LO = FLD_LO[f];
    localparam int W  = FLD_W[f];
    assign fld_ok[f] = ~fld_en[f] | (cur_t[LO +: W] == tgt_t[LO +: W]);
  end

  assign all_ok = (|fld_en) & (&fld_ok);
endmodule

// File: rtl/alm_channel.sv
module alm_channel
  import alm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic fld_hit,
  input  logic rpt,
  input  logic arm,
  input  logic clr,
  output logic fire,
  output logic flag
);
  alm_state_t st_q, st_d;
  logic       st_en;

  always_comb begin
    fire         = tick & st_q.armed & fld_hit;
    st_d.flag    = fire | (st_q.flag & ~clr);
    st_d.armed   = arm | (st_q.armed & ~(fire & ~rpt));
    st_en        = tick | arm | clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  assign flag = st_q.flag;
endmodule

// File: rtl/alarm_pair_cmp.sv
module alarm_pair_cmp
  import alm_pkg::*;
#(
  parameter  int NUM_AL = 2,
  parameter  int SEC_W  = 6,
  parameter  int MIN_W  = 6,
  parameter  int HOUR_W = 5,
  parameter  int DOW_W  = 3,
  parameter  int DAY_W  = 5,
  parameter  int MON_W  = 4,
  localparam int TW     = SEC_W + MIN_W + HOUR_W + DOW_W + DAY_W + MON_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic [SEC_W-1:0]         cur_sec,
  input  logic [MIN_W-1:0]         cur_min,
  input  logic [HOUR_W-1:0]        cur_hour,
  input  logic [DOW_W-1:0]         cur_dow,
  input  logic [DAY_W-1:0]         cur_day,
  input  logic [MON_W-1:0]         cur_mon,
  input  logic [NUM_AL*TW-1:0]     alm_time,
  input  logic [NUM_AL*NFIELD-1:0] alm_en,
  input  logic [NUM_AL-1:0]        alm_rpt,
  input  logic [NUM_AL-1:0]        alm_arm,
  input  logic [NUM_AL-1:0]        flag_clr,
  input  logic [NUM_AL-1:0]        irq_en,
  output logic [NUM_AL-1:0]        alm_flag,
  output logic                     irq_n
);
  logic              rst_sync_n;
  logic [TW-1:0]     cur_t;
  logic [NUM_AL-1:0] fld_hit;
  logic [NUM_AL-1:0] fire_vec;

  alm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign cur_t = {cur_mon, cur_day, cur_dow, cur_hour, cur_min, cur_sec};

  for (genvar i = 0; i < NUM_AL; i++) begin : g_al
    alm_match #(
      .SEC_W (SEC_W), .MIN_W (MIN_W), .HOUR_W (HOUR_W),
      .DOW_W (DOW_W), .DAY_W (DAY_W), .MON_W  (MON_W)
    ) u_match (
      .cur_t  (cur_t),
      .tgt_t  (alm_time[i*TW +: TW]),
      .fld_en (alm_en[i*NFIELD +: NFIELD]),
      .all_ok (fld_hit[i])
    );

    alm_channel u_chan (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .tick    (tick),
      .fld_hit (fld_hit[i]),
      .rpt     (alm_rpt[i]),
      .arm     (alm_arm[i]),
      .clr     (flag_clr[i]),
      .fire    (fire_vec[i]),
      .flag    (alm_flag[i])
    );
  end

  assign irq_n = ~|(alm_flag & irq_en);
endmodule

// File: rtl/alarm_pair_cmp_chk.sv
module alarm_pair_cmp_chk #(
  parameter int NUM_AL = 2,
  parameter int NF     = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic [NUM_AL*NF-1:0] alm_en,
  input logic [NUM_AL-1:0]    flag_clr,
  input logic [NUM_AL-1:0]    alm_flag,
  input logic                 irq_n,
  input logic [NUM_AL-1:0]    fire
);
  for (genvar i = 0; i < NUM_AL; i++) begin : g_chk
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fire[i] |=> alm_flag[i]);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr[i] && !fire[i]) |=> !alm_flag[i]);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_flag[i] && !flag_clr[i]) |=> alm_flag[i]);

    assert_tick_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !alm_flag[i]) |=> !alm_flag[i]);

    assert_no_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_en[i*NF +: NF] == '0) |-> !fire[i]);
  end

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (|alm_flag));
endmodule

bind alarm_pair_cmp alarm_pair_cmp_chk #(.NUM_AL(NUM_AL), .NF(alm_pkg::NFIELD)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .alm_en   (alm_en),
  .flag_clr (flag_clr),
  .alm_flag (alm_flag),
  .irq_n    (irq_n),
  .fire     (fire_vec)
);

// File: tb/alarm_pair_cmp_test.sv
module alarm_pair_cmp_test;
  localparam int TW = 29;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [TW-1:0] cur = '0;
  logic [2*TW-1:0] alm_time = '0;
  logic [11:0]   alm_en = '0;
  logic [1:0]    alm_rpt = '0;
  logic [1:0]    alm_arm = '0;
  logic [1:0]    flag_clr = '0;
  logic [1:0]    irq_en = 2'b11;
  logic [1:0]    alm_flag;
  logic          irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [1:0] fl;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  alarm_pair_cmp uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cur_sec  (cur[5:0]),
    .cur_min  (cur[11:6]),
    .cur_hour (cur[16:12]),
    .cur_dow  (cur[19:17]),
    .cur_day  (cur[24:20]),
    .cur_mon  (cur[28:25]),
    .alm_time (alm_time),
    .alm_en   (alm_en),
    .alm_rpt  (alm_rpt),
    .alm_arm  (alm_arm),
    .flag_clr (flag_clr),
    .irq_en   (irq_en),
    .alm_flag (alm_flag),
    .irq_n    (irq_n)
  );

  function automatic logic [TW-1:0] tpack(input int mo, input int dy, input int dw,
                                          input int hr, input int mi, input int se);
    return {mo[3:0], dy[4:0], dw[2:0], hr[4:0], mi[5:0], se[5:0]};
  endfunction

  task automatic check(input logic [1:0] fl_a, input logic irq_a,
                       input logic [1:0] fl_e, input logic irq_e, input string tag);
    checks++;
    if (fl_a !== fl_e || irq_a !== irq_e) begin
      fails++;
      $display("FAIL %s: flags=%b irq_n=%b expected flags=%b irq_n=%b",
               tag, fl_a, irq_a, fl_e, irq_e);
    end
  endtask

  task automatic step(input logic tk, input logic [TW-1:0] t, input logic [1:0] arm_v,
                      input logic [1:0] clr_v, input logic [1:0] ef, input string tag);
    exp_t e;
    @(negedge clk);
    tick     = tk;
    cur      = t;
    alm_arm  = arm_v;
    flag_clr = clr_v;
    e.fl  = ef;
    e.irq = ~|(ef & irq_en);
    e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    #3;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(alm_flag, irq_n, e.fl, e.irq, e.tag);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    logic [TW-1:0] t_ref, t_s44, t_dw5, t_dw2;
    t_ref = tpack(3, 15, 2, 10, 30, 45);
    t_s44 = tpack(3, 15, 2, 10, 30, 44);
    t_dw5 = tpack(3, 15, 5, 10, 30, 45);
    t_dw2 = tpack(3, 15, 2, 0, 0, 0);

    alm_time[0 +: TW]  = t_ref;
    alm_time[TW +: TW] = tpack(3, 15, 2, 10, 30, 0);
    alm_en[5:0]  = 6'b111111;
    alm_en[11:6] = 6'b000010;

    repeat (3) @(posedge clk);
    #2;
    check(alm_flag, irq_n, 2'b00, 1'b1, "R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    step(1, t_ref, 2'b00, 2'b00, 2'b00, "R1 disarmed after reset");
    step(0, t_ref, 2'b11, 2'b00, 2'b00, "R8 arm pulse alone");
    step(1, t_s44, 2'b00, 2'b00, 2'b10, "R3 R11 R12 sec mismatch, minute-only alarm fires");
    step(0, t_ref, 2'b00, 2'b00, 2'b10, "R5 match without tick");
    step(1, t_ref, 2'b00, 2'b00, 2'b11, "R2 full match fires");
    step(0, t_ref, 2'b00, 2'b10, 2'b01, "R6 clear one flag");
    step(1, t_ref, 2'b00, 2'b01, 2'b00, "R8 single-shot disarmed");
    step(0, t_ref, 2'b01, 2'b00, 2'b00, "R8 re-arm");
    step(1, t_ref, 2'b00, 2'b01, 2'b01, "R7 set beats clear");
    irq_en = 2'b10;
    step(0, t_ref, 2'b00, 2'b00, 2'b01, "R10 masked flag keeps irq high");

    alm_rpt[1] = 1'b1;
    step(0, t_ref, 2'b10, 2'b00, 2'b01, "R9 arm repeat channel");
    step(1, t_s44, 2'b00, 2'b01, 2'b10, "R9 repeat fire");
    step(0, t_s44, 2'b00, 2'b10, 2'b00, "R6 clear repeat flag");
    step(1, t_s44, 2'b00, 2'b00, 2'b10, "R9 fires again without re-arm");

    alm_en[11:6] = 6'b000000;
    step(0, t_s44, 2'b00, 2'b10, 2'b00, "R6 clear before empty-enable test");
    step(1, t_s44, 2'b00, 2'b00, 2'b00, "R4 no enabled field never fires");

    alm_en[5:0] = 6'b001000;
    step(0, t_ref, 2'b01, 2'b00, 2'b00, "R8 re-arm dow alarm");
    step(1, t_dw5, 2'b00, 2'b00, 2'b00, "R12 day-of-week mismatch");
    step(1, t_dw2, 2'b00, 2'b00, 2'b01, "R3 only day-of-week compared");
    irq_en = 2'b11;
    step(0, t_dw2, 2'b00, 2'b00, 2'b01, "R10 enabled flag drives irq low");

    @(negedge clk);
    tick = 1'b0;
    alm_arm = '0;
    flag_clr = '0;
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule